// File: doc/BRIEF.md
# Line-Locked Comb Sampling Clock Generator

This block turns a master clock running at six times the colour subcarrier into a sampling clock enable at three times the subcarrier for a line comb filter. It divides the master clock by two. Once per line it freezes the divider for one master cycle. That slip turns the sample grid by half a sampling period, which is needed because a line does not hold a whole number of subcarrier cycles. It also issues a line-start strobe for the line delay memory and a phase bit that tells the two line phases apart.

Line timing comes from a master-cycle counter. A vertical sync pulse arms a resync. The next horizontal sync pulse then forces the counter back to line position 0, so the line phase is corrected once per field. While bypass is high every output is quiet and all state is held at its start values. When bypass is released, the block free-runs unlocked until the next field resync. A PLL outside the block provides the master clock, and the sync pulses come in already detected and synchronous to that clock.

Top module: `comb_clk_gen`

## Requirements
- R1: While rst_ni is low, samp_en_o, line_start_o, phase_o and locked_o are all 0.
- R2: samp_en_o is never high in two consecutive master cycles.
- R3: A line spans LINE_LEN master cycles, where LINE_LEN is odd and is 1365 by default. Line position 0 is the first cycle of a line. samp_en_o is high exactly at the even positions 2, 4, ... LINE_LEN-1, which gives (LINE_LEN-1)/2 enables per line.
- R4: Position 0 is the held divider cycle and never carries an enable. The last enable of one line and the first enable of the next are therefore three master cycles apart, which is the half-sample phase slip.
- R5: line_start_o is high only at position 2. That is the first enable after the slip, so the strobe is one sample wide.
- R6: phase_o toggles on each natural line wrap. It is 0 after reset, after a resync and in bypass.
- R7: A cycle with vsync_i high arms a resync. The first later cycle with hsync_i high, vsync_i low and bypass_i low resyncs the block: the next cycle is at position 0. Any further hsync_i pulse before the next vsync_i has no effect.
- R8: An hsync_i pulse while not armed has no effect. So does an hsync_i pulse in the same cycle as vsync_i.
- R9: locked_o rises in the cycle after a resync. It falls only through bypass or reset.
- R10: While bypass_i is high, samp_en_o and line_start_o are 0 in that same cycle. The counters, the divider, the arm and locked_o are held cleared, and vsync_i is ignored.
- R11: After reset, or after bypass is released, the block free-runs from position 0 with locked_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, six times subcarrier |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync detect pulse |
| vsync_i | input | 1 | Vertical sync detect pulse |
| bypass_i | input | 1 | Bypass mode; halts clock generation |
| samp_en_o | output | 1 | Sampling clock enable, three times subcarrier |
| line_start_o | output | 1 | Line-start strobe for the line delay memory |
| phase_o | output | 1 | Line phase indicator |
| locked_o | output | 1 | Set after the first field resync |

## Verification
The assertions check on every cycle the properties that hold locally. These are: no two adjacent enables, no enable on the held cycle, a strobe only on an enable that follows a gap, silence in bypass, a phase toggle at each wrap, position 0 after a resync, and a legal cause for every change of locked_o. The bench scenarios are needed for the properties that depend on history. These are the exact enable positions and the count per line, the line-to-line phase alternation, and which hsync pulses may resync. It also covers arming only by vsync, the coincident vsync and hsync case, vsync ignored during bypass, and the unlocked restart after bypass.

// File: rtl/comb_clk_pkg.sv
package comb_clk_pkg;
  localparam int unsigned DefLineLen = 1365;
  localparam int unsigned StartPos   = 2;
endpackage

// File: rtl/clkg_resync.sv
module clkg_resync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic vsync_i,
  input  logic bypass_i,
  output logic realign_o,
  output logic locked_o
);
  logic armed_q, locked_q;

  assign realign_o = hsync_i & armed_q & ~vsync_i & ~bypass_i;
  assign locked_o  = locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
    end else if (bypass_i) begin
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
    end else if (vsync_i) begin
      armed_q  <= 1'b1;
    end else if (realign_o) begin
      armed_q  <= 1'b0;
      locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/clkg_line_ctr.sv
module clkg_line_ctr #(
  parameter int unsigned LINE_LEN = 1365,
  localparam int unsigned CW = $clog2(LINE_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bypass_i,
  input  logic          realign_i,
  output logic [CW-1:0] cnt_o,
  output logic          hold_o,
  output logic          phase_o
);
  localparam logic [CW-1:0] LastPos = CW'(LINE_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (bypass_i || realign_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LastPos) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign hold_o  = (cnt_q == '0);
  assign phase_o = phase_q;
endmodule

// File: rtl/clkg_div.sv
module clkg_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic realign_i,
  input  logic hold_i,
  output logic div_o
);
  logic div_q;

  // hold_i freezes the toggle for one master cycle: 180 deg slip
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    div_q <= 1'b0;
    else if (bypass_i || realign_i) div_q <= 1'b0;
    else if (!hold_i)               div_q <= ~div_q;
  end

  assign div_o = div_q;
endmodule

// File: rtl/comb_clk_gen.sv
module comb_clk_gen #(
  parameter int unsigned LINE_LEN = comb_clk_pkg::DefLineLen
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic vsync_i,
  input  logic bypass_i,
  output logic samp_en_o,
  output logic line_start_o,
  output logic phase_o,
  output logic locked_o
);
  localparam int unsigned CW = $clog2(LINE_LEN);
  localparam logic [CW-1:0] StartPos = CW'(comb_clk_pkg::StartPos);

  logic          realign_w, hold_w, div_w;
  logic [CW-1:0] cnt_w;

  clkg_resync u_resync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hsync_i  (hsync_i),
    .vsync_i  (vsync_i),
    .bypass_i (bypass_i),
    .realign_o(realign_w),
    .locked_o (locked_o)
  );

  clkg_line_ctr #(.LINE_LEN(LINE_LEN)) u_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (bypass_i),
    .realign_i(realign_w),
    .cnt_o    (cnt_w),
    .hold_o   (hold_w),
    .phase_o  (phase_o)
  );

  clkg_div u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (bypass_i),
    .realign_i(realign_w),
    .hold_i   (hold_w),
    .div_o    (div_w)
  );

  assign samp_en_o    = div_w & ~bypass_i;
  assign line_start_o = samp_en_o & (cnt_w == StartPos);
endmodule

// File: rtl/comb_clk_gen_chk.sv
module comb_clk_gen_chk #(
  parameter int unsigned LINE_LEN = 1365,
  localparam int unsigned CW = $clog2(LINE_LEN)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hsync_i,
  input logic          bypass_i,
  input logic          samp_en_o,
  input logic          line_start_o,
  input logic          phase_o,
  input logic          locked_o,
  input logic          realign_w,
  input logic [CW-1:0] cnt_w
);
  p_no_adjacent_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_en_o |=> !samp_en_o);
  p_hold_no_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w == '0) |-> !samp_en_o);
  p_start_on_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_o |-> samp_en_o && !$past(samp_en_o));
  p_wrap_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w == CW'(LINE_LEN - 1) && !realign_w && !bypass_i) |=> (phase_o != $past(phase_o)));
  p_realign_pos0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_w |=> (cnt_w == '0) && !phase_o);
  p_lock_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(hsync_i));
  p_unlock_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(bypass_i));
  p_bypass_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> !samp_en_o && !line_start_o);
endmodule

bind comb_clk_gen comb_clk_gen_chk #(.LINE_LEN(LINE_LEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hsync_i     (hsync_i),
  .bypass_i    (bypass_i),
  .samp_en_o   (samp_en_o),
  .line_start_o(line_start_o),
  .phase_o     (phase_o),
  .locked_o    (locked_o),
  .realign_w   (realign_w),
  .cnt_w       (cnt_w)
);

// File: tb/sim_comb_clk_gen.sv
module sim_comb_clk_gen;
  localparam int unsigned L = 21;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hs = 1'b0, vs = 1'b0, byp = 1'b0;
  logic en, ls, ph, lk;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  comb_clk_gen #(.LINE_LEN(L)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .hsync_i(hs), .vsync_i(vs), .bypass_i(byp),
    .samp_en_o(en), .line_start_o(ls), .phase_o(ph), .locked_o(lk)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int cyc);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  // model state: k = master cycles since position 0
  int k = 0;
  bit m_arm = 0, m_lock = 0;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 samp_en", en, 1'b0, -1);
    chk("R1 line_start", ls, 1'b0, -1);
    chk("R1 phase", ph, 1'b0, -1);
    chk("R1 locked", lk, 1'b0, -1);
    rst_ni = 1'b1;
    for (int c = 0; c < 330; c++) begin
      int pos;
      bit e_en, e_ls, e_ph, realign;
      pos  = k % L;
      e_en = !byp && pos != 0 && (pos % 2 == 0);   // R3 R4 R10
      e_ls = e_en && pos == 2;                      // R5
      e_ph = ((k / L) % 2) == 1;                    // R6
      chk("R2 R3 R4 R10 R11 samp_en", en, e_en, c);
      chk("R5 line_start", ls, e_ls, c);
      chk("R6 phase", ph, e_ph, c);
      chk("R7 R8 R9 R11 locked", lk, m_lock, c);
      // stimulus for this cycle
      hs  = (c == 30) || (c == 55) || (c == 60) || (c == 100) || (c == 103) ||
            (c == 170) || (c == 201) || (c == 262);
      vs  = (c == 50) || (c == 100) || (c == 155) || (c == 200) || (c == 250);
      byp = (c >= 150 && c <= 160);
      realign = !byp && hs && m_arm && !vs;
      if (byp) begin
        k = 0; m_arm = 0; m_lock = 0;
      end else begin
        if (realign) begin k = 0; m_lock = 1; end
        else k++;
        if (vs) m_arm = 1;
        else if (realign) m_arm = 0;
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule